// File: doc/BRIEF.md
# Lane-Group Matrix Fragment Store Unit

The unit takes the register fragments held by a group of 32 lanes and writes one, two or four small matrices into a banked scratchpad. Every lane presents four 32-bit registers, where register k holds that lane's piece of matrix k, and one row-start address. A configuration selects the shape and element size (8x8 with 16-bit elements, or 16x8 with 8-bit elements), the number of matrices, and whether each matrix goes out column-major. On a start pulse the unit captures every lane input. It then checks that the configuration is legal and that the addresses are aligned. After that it issues one 16-byte write per cycle on a plain memory write port, and it pulses done after the final write.

Every matrix takes exactly eight 16-byte writes. Write t (t = 8k + j, for matrix k and line j) goes to the address that lane t supplied. The rows of a matrix can therefore sit anywhere in the scratchpad. For an illegal configuration the unit writes nothing and reports the fault through err together with done.

The controller has five states. ST_IDLE waits for start. ST_CHECK evaluates the captured configuration. ST_WRITE issues one write per cycle. ST_FIN raises done. ST_FAULT raises err and done. The transitions are: ST_IDLE to ST_CHECK on start; ST_CHECK to ST_WRITE when legal and to ST_FAULT when not; ST_WRITE stays in ST_WRITE until the last write and then moves to ST_FIN; ST_FIN and ST_FAULT both return to ST_IDLE.

Top module: `wfs_store_unit`

## Requirements
- R1: After reset, busy, wr_en, done and err are all low.
- R2: A start pulse seen in ST_IDLE captures every lane address, every lane register and the configuration. Changes to any of these inputs after that edge have no effect on the writes.
- R3: The first write appears in the second cycle after the start edge, and writes follow on consecutive cycles. The number of writes is 8, 16 or 32 for mat_cnt codes 0, 1 and 2 respectively.
- R4: Writes go in order: matrix 0 lines 0 to 7, then matrix 1, and so on. Write t uses the address from lane t, taken from bits [16t+15:16t] of lane_addr.
- R5: With shape_tall=0, elem_byte=0 and trans=0, row r of matrix k puts register k of lane 4r+c into wr_data bits [32c+31:32c]. Register k of lane L sits at lane_frag bits [(4L+k)*32 +: 32].
- R6: With shape_tall=0, elem_byte=0 and trans=1, write j of matrix k carries column j. Its 16-bit element i, at bits [16i+15:16i], is the lower half of register k of lane 4i+j/2 when j is even, and the upper half when j is odd.
- R7: With shape_tall=1, elem_byte=1 and trans=1, write j of matrix k carries column j of a 16x8 byte matrix. Its byte i is byte j%4 of register k of lane 2i+j/4, where byte 0 is the least significant.
- R8: done is high for exactly one cycle, the cycle after the last write, with err low and no write in that cycle.
- R9: These configurations are illegal: shape_tall=1 with elem_byte=0, shape_tall=1 with trans=0, shape_tall=0 with elem_byte=1, and mat_cnt=3. For each of them, err and done are high together for one cycle in the second cycle after start, and no write is issued.
- R10: A used address (lanes 0 to 8*count-1) with any of its low four bits set is treated as illegal, as in R9. Addresses from lanes beyond that range have no effect.
- R11: A start pulse while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a store; sampled in ST_IDLE only |
| shape_tall | input | 1 | 1 selects 16x8, 0 selects 8x8 |
| elem_byte | input | 1 | 1 selects 8-bit elements, 0 selects 16-bit |
| trans | input | 1 | 1 writes column-major |
| mat_cnt | input | 2 | Matrix count code: 0=1, 1=2, 2=4, 3 illegal |
| lane_addr | input | 32*AW | Row-start address per lane, lane L at bits [AW*L +: AW] |
| lane_frag | input | 4096 | Four 32-bit registers per lane |
| busy | output | 1 | High from the start edge until the return to ST_IDLE |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | AW | Write address (16-byte aligned) |
| wr_data | output | 128 | Write data, byte 0 in bits [7:0] |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle fault pulse, together with done |

## Verification
Counting from the clock edge that samples start, busy is due one cycle later. Write t is due t+2 cycles later, done follows 8*count+2 cycles later, and a fault pulse arrives 2 cycles later. The bench counts these cycles at each falling edge after the start edge. In every cycle it compares wr_en, wr_addr, wr_data, done, err and busy with what is due in that cycle, so a write that comes early, late or is missing fails at its own cycle. It sweeps every legal shape and count, all illegal codes, and misaligned addresses both inside and outside the used lanes. It also scrambles the inputs and fires a second start mid-run to show that the captured values govern the whole run.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
    localparam int LANES   = 32;
    localparam int NREG    = 4;
    localparam int RW      = 32;
    localparam int LINE_W  = 128;
    localparam int ROWS    = 8;
    localparam int IDX_W   = $clog2(LANES);
    localparam int FRAG_W  = LANES * NREG * RW;

    typedef enum logic [1:0] {
        MODE_H16_ROW = 2'd0,
        MODE_H16_COL = 2'd1,
        MODE_B8_COL  = 2'd2
    } frag_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_WRITE = 3'd2,
        ST_FIN   = 3'd3,
        ST_FAULT = 3'd4
    } wfs_state_e;

    function automatic int mats_of(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/wfs_legality.sv
module wfs_legality
    import wfs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                  shape_tall,
    input  logic                  elem_byte,
    input  logic                  trans,
    input  logic [1:0]            mat_cnt,
    input  logic [LANES*AW-1:0]   lane_addr,
    output logic                  cfg_ok,
    output frag_mode_e            mode,
    output logic [IDX_W-1:0]      last_idx
);
    localparam int ALIGN_BITS = $clog2(LINE_W / 8);

    int n_mats;

    always_comb begin
        n_mats   = mats_of(mat_cnt);
        cfg_ok   = (n_mats != 0);
        last_idx = IDX_W'(ROWS * (n_mats == 0 ? 1 : n_mats) - 1);
        if (shape_tall) begin
            mode = MODE_B8_COL;
            if (!elem_byte || !trans) cfg_ok = 1'b0;
        end else begin
            mode = trans ? MODE_H16_COL : MODE_H16_ROW;
            if (elem_byte) cfg_ok = 1'b0;
        end
        for (int l = 0; l < LANES; l++) begin
            if ((l < ROWS * n_mats) && (lane_addr[l*AW +: ALIGN_BITS] != '0))
                cfg_ok = 1'b0;
        end
    end
endmodule

// File: rtl/wfs_gather.sv
module wfs_gather
    import wfs_pkg::*;
(
    input  logic [FRAG_W-1:0] frag,
    input  frag_mode_e        mode,
    input  logic [1:0]        mat,
    input  logic [2:0]        line,
    output logic [LINE_W-1:0] data
);
    int ln;
    int li;
    int mi;

    always_comb begin
        data = '0;
        ln   = 0;
        li   = int'(line);
        mi   = int'(mat);
        unique case (mode)
            MODE_H16_ROW: begin
                for (int c = 0; c < 4; c++) begin
                    ln = 4 * li + c;
                    data[32*c +: 32] = frag[(ln*NREG + mi)*RW +: 32];
                end
            end
            MODE_H16_COL: begin
                for (int i = 0; i < 8; i++) begin
                    ln = 4 * i + li / 2;
                    data[16*i +: 16] = frag[(ln*NREG + mi)*RW + 16*(li % 2) +: 16];
                end
            end
            MODE_B8_COL: begin
                for (int i = 0; i < 16; i++) begin
                    ln = 2 * i + li / 4;
                    data[8*i +: 8] = frag[(ln*NREG + mi)*RW + 8*(li % 4) +: 8];
                end
            end
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/wfs_seq.sv
module wfs_seq
    import wfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_ok,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] idx,
    output logic             capture,
    output logic             busy,
    output logic             wr_en,
    output logic             done,
    output logic             err
);
    wfs_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_CHECK;
            ST_CHECK: nxt = cfg_ok ? ST_WRITE : ST_FAULT;
            ST_WRITE: if (idx == last_idx) nxt = ST_FIN;
            ST_FIN:   nxt = ST_IDLE;
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_CHECK)      idx <= '0;
            else if (state == ST_WRITE) idx <= idx + 1'b1;
        end
    end

    always_comb begin
        capture = 1'b0;
        busy    = 1'b1;
        wr_en   = 1'b0;
        done    = 1'b0;
        err     = 1'b0;
        unique case (state)
            ST_IDLE:  begin busy = 1'b0; capture = start; end
            ST_CHECK: ;
            ST_WRITE: wr_en = 1'b1;
            ST_FIN:   done = 1'b1;
            ST_FAULT: begin done = 1'b1; err = 1'b1; end
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/wfs_store_unit.sv
module wfs_store_unit
    import wfs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                shape_tall,
    input  logic                elem_byte,
    input  logic                trans,
    input  logic [1:0]          mat_cnt,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [FRAG_W-1:0]   lane_frag,
    output logic                busy,
    output logic                wr_en,
    output logic [AW-1:0]       wr_addr,
    output logic [LINE_W-1:0]   wr_data,
    output logic                done,
    output logic                err
);
    logic                capture;
    logic                q_tall, q_byte, q_trans;
    logic [1:0]          q_cnt;
    logic [LANES*AW-1:0] q_addr;
    logic [FRAG_W-1:0]   q_frag;
    logic                cfg_ok;
    frag_mode_e          mode;
    logic [IDX_W-1:0]    last_idx;
    logic [IDX_W-1:0]    idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_tall  <= 1'b0;
            q_byte  <= 1'b0;
            q_trans <= 1'b0;
            q_cnt   <= '0;
            q_addr  <= '0;
            q_frag  <= '0;
        end else if (capture) begin
            q_tall  <= shape_tall;
            q_byte  <= elem_byte;
            q_trans <= trans;
            q_cnt   <= mat_cnt;
            q_addr  <= lane_addr;
            q_frag  <= lane_frag;
        end
    end

    wfs_legality #(.AW(AW)) u_legal (
        .shape_tall (q_tall),
        .elem_byte  (q_byte),
        .trans      (q_trans),
        .mat_cnt    (q_cnt),
        .lane_addr  (q_addr),
        .cfg_ok     (cfg_ok),
        .mode       (mode),
        .last_idx   (last_idx)
    );

    wfs_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_ok   (cfg_ok),
        .last_idx (last_idx),
        .idx      (idx),
        .capture  (capture),
        .busy     (busy),
        .wr_en    (wr_en),
        .done     (done),
        .err      (err)
    );

    wfs_gather u_gather (
        .frag (q_frag),
        .mode (mode),
        .mat  (idx[4:3]),
        .line (idx[2:0]),
        .data (wr_data)
    );

    assign wr_addr = q_addr[int'(idx)*AW +: AW];
endmodule

// File: rtl/wfs_store_unit_chk.sv
module wfs_store_unit_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          done,
    input logic          err
);
    // R10
    wr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[3:0] == 4'h0));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !wr_en));

    // R3
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R11
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !wr_en && !done));

    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind wfs_store_unit wfs_store_unit_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .done    (done),
    .err     (err)
);

// File: tb/wfs_store_unit_bench.sv
`timescale 1ns/1ps
module wfs_store_unit_bench;
    localparam int AW = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               shape_tall = 1'b0, elem_byte = 1'b0, trans = 1'b0;
    logic [1:0]         mat_cnt = '0;
    logic [32*AW-1:0]   lane_addr = '0;
    logic [4095:0]      lane_frag = '0;
    logic               busy, wr_en, done, err;
    logic [AW-1:0]      wr_addr;
    logic [127:0]       wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wfs_store_unit #(.AW(AW)) u_wfs_store_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .shape_tall(shape_tall),
        .elem_byte(elem_byte), .trans(trans), .mat_cnt(mat_cnt),
        .lane_addr(lane_addr), .lane_frag(lane_frag), .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .err(err)
    );

    function automatic logic [7:0] fbyte(int l, int k, int b, int seed);
        return 8'(((l * 4 + b) * 3) + k * 61 + seed * 17);
    endfunction

    function automatic logic [AW-1:0] laddr(int l, int seed);
        return AW'((((l * 5) + seed * 3) % 64) * 16 + 256);
    endfunction

    function automatic logic [15:0] half16(int l, int k, int h, int seed);
        return {fbyte(l, k, 2*h+1, seed), fbyte(l, k, 2*h, seed)};
    endfunction

    // element of the logical matrix; 8x8 halfwords or 16x8 bytes
    function automatic logic [127:0] exp_line(int mode, int k, int j, int seed);
        logic [127:0] v = '0;
        if (mode == 0) begin
            for (int col = 0; col < 8; col++)
                v[16*col +: 16] = half16(4*j + col/2, k, col % 2, seed);
        end else if (mode == 1) begin
            for (int r = 0; r < 8; r++)
                v[16*r +: 16] = half16(4*r + j/2, k, j % 2, seed);
        end else begin
            for (int r = 0; r < 16; r++)
                v[8*r +: 8] = fbyte(2*r + j/4, k, j % 4, seed);
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load(input int seed, input int bad_lane);
        for (int l = 0; l < 32; l++) begin
            lane_addr[l*AW +: AW] = laddr(l, seed) + ((l == bad_lane) ? AW'(4) : AW'(0));
            for (int k = 0; k < 4; k++)
                for (int b = 0; b < 4; b++)
                    lane_frag[(l*4 + k)*32 + 8*b +: 8] = fbyte(l, k, b, seed);
        end
    endtask

    task automatic run_cfg(input bit tall, input bit bt, input bit tr, input logic [1:0] cc,
                           input int seed, input int bad_lane, input bit exp_err, input bit poke);
        int n;
        int mode;
        n    = (cc == 0) ? 1 : (cc == 1) ? 2 : (cc == 2) ? 4 : 0;
        mode = tall ? 2 : (tr ? 1 : 0);
        @(negedge clk);
        load(seed, bad_lane);
        shape_tall = tall; elem_byte = bt; trans = tr; mat_cnt = cc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: scramble everything after the capture edge
        lane_frag = ~lane_frag;
        lane_addr = ~lane_addr;
        shape_tall = ~tall; trans = ~tr; mat_cnt = ~cc;
        chk(busy && !wr_en && !done && !err, "R3", "cycle1 busy/wr/done",
            {busy, wr_en, done, err}, 4'b1000);
        if (exp_err) begin
            @(negedge clk);
            chk(err && done && !wr_en, "R9", "fault pulse", {err, done, wr_en}, 3'b110);
            @(negedge clk);
            chk(!busy && !err && !done && !wr_en, "R10", "after fault idle",
                {busy, err, done, wr_en}, 4'b0000);
        end else begin
            for (int t = 0; t < 8*n; t++) begin
                @(negedge clk);
                if (poke && t == 1) start = 1'b1;
                if (poke && t == 2) start = 1'b0;
                chk(wr_en && !done, "R3", $sformatf("write %0d strobe", t),
                    {wr_en, done}, 2'b10);
                chk(wr_addr == laddr(t, seed), "R4", $sformatf("write %0d addr", t),
                    128'(wr_addr), 128'(laddr(t, seed)));
                chk(wr_data == exp_line(mode, t / 8, t % 8, seed),
                    (mode == 0) ? "R5" : (mode == 1) ? "R6" : "R7",
                    $sformatf("write %0d data", t), wr_data, exp_line(mode, t / 8, t % 8, seed));
            end
            start = 1'b0;
            @(negedge clk);
            chk(done && !err && !wr_en, "R8", "done pulse", {done, err, wr_en}, 3'b100);
            @(negedge clk);
            chk(!busy && !done && !wr_en, poke ? "R11" : "R8", "idle after done",
                {busy, done, wr_en}, 3'b000);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !wr_en && !done && !err, "R1", "reset outputs",
            {busy, wr_en, done, err}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wr_en && !done && !err, "R1", "idle after reset",
            {busy, wr_en, done, err}, 4'b0000);
        // legal sweep: three layouts x three counts
        for (int m = 0; m < 3; m++)
            for (int c = 0; c < 3; c++)
                run_cfg(m == 2, m == 2, m != 0, 2'(c), m * 3 + c + 1, -1, 1'b0, 1'b0);
        // R11: start mid-run
        run_cfg(1'b0, 1'b0, 1'b1, 2'd1, 21, -1, 1'b0, 1'b1);
        // R9: illegal configurations
        run_cfg(1'b1, 1'b0, 1'b1, 2'd0, 30, -1, 1'b1, 1'b0);
        run_cfg(1'b1, 1'b1, 1'b0, 2'd0, 31, -1, 1'b1, 1'b0);
        run_cfg(1'b0, 1'b1, 1'b0, 2'd0, 32, -1, 1'b1, 1'b0);
        run_cfg(1'b0, 1'b0, 1'b0, 2'd3, 33, -1, 1'b1, 1'b0);
        // R10: misaligned used lane faults, unused lane ignored
        run_cfg(1'b0, 1'b0, 1'b0, 2'd1, 34, 15, 1'b1, 1'b0);
        run_cfg(1'b1, 1'b1, 1'b1, 2'd2, 35, 0, 1'b1, 1'b0);
        run_cfg(1'b0, 1'b0, 1'b0, 2'd1, 36, 16, 1'b0, 1'b0);
        run_cfg(1'b0, 1'b0, 1'b1, 2'd0, 37, 31, 1'b0, 1'b0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule